// File: doc/BRIEF.md
# Embedded-Clock Frame Aligner With Lock Detect

This block sits behind a serial line receiver that already delivers one recovered bit per strobe. The line carries 12-bit frames: a framing bit that is always 1, ten payload bits, and a closing bit that is always 0. Because every frame has a guaranteed 1-to-0 boundary, the aligner can find the frame phase by trying bit positions one at a time until the boundary pattern repeats.

While searching, the block tests one candidate phase per frame. After a failed test it moves the candidate one bit later. After a run of good frames at one phase it declares lock on an active-low lock output. Once locked, it hands each payload word to the next stage with a one-cycle valid strobe. Frames that break the framing rule while lock is still held are passed on with a suspect flag, so upper logic can ask for those words again. A run of bad frames drops lock and restarts the search. While unlocked, all word outputs stay quiet and zero.

A sender can force quick acquisition by repeating the alignment symbol, six 1s followed by six 0s. Only one of the twelve phases of this symbol meets the framing rule, so the search always settles on the true boundary.

Top module: `ecf_aligner`

## Requirements
- R1: After a synchronous reset, lock_n is 1 and word_valid, word_suspect and word_data are all 0.
- R2: A frame is 12 strobed bits in arrival order: framing bit (must be 1), payload bits 0 through 9 (bit 0 arrives first), then closing bit (must be 0). word_data[i] carries payload bit i.
- R3: While unlocked, lock_n falls in the cycle after the strobe that completes the 8th consecutive frame meeting the framing rule at one phase. That 8th frame is not delivered as a word, and the 7 frames before it do not change lock_n.
- R4: While unlocked, every frame that breaks the framing rule moves the candidate phase one bit later: the next frame test happens 13 strobes after the failed one instead of 12. A repeated alignment symbol, starting from any offset, gives lock within 252 strobes, and lock is declared on the strobe of a closing 0 of the symbol.
- R5: While locked, each frame meeting the framing rule produces word_valid high for exactly one cycle. That cycle follows the strobe of the closing bit, with word_suspect low and the payload on word_data. No word appears in the middle of a frame.
- R6: While locked, lock_n rises in the cycle after the 4th consecutive frame that breaks the framing rule. Runs of 1 to 3 bad frames that end in a good frame keep lock.
- R7: While locked, the 1st, 2nd and 3rd frames of a bad run are still delivered with word_valid and word_suspect both high and their payload on word_data. The 4th bad frame, which drops lock, is not delivered.
- R8: Whenever lock_n is 1, word_valid and word_suspect are 0 and word_data is all zeros.
- R9: Cycles with bit_stb low are ignored: bit_in is not sampled and framing is unaffected, no matter how many idle cycles separate two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | High for one cycle per received serial bit |
| bit_in | input | 1 | Serial bit value, sampled when bit_stb is high |
| lock_n | output | 1 | 0 when frame-locked, 1 while searching or after reset |
| word_valid | output | 1 | One-cycle strobe for a delivered payload word |
| word_data | output | 10 | Payload word, zero when word_valid is low |
| word_suspect | output | 1 | Marks a delivered word whose frame broke the framing rule |

## Verification
The hardest condition to reach from the ports is the border between keeping and losing lock. Exactly three bad frames followed by a good one must keep lock and flag three suspect words, while a fourth bad frame must drop lock. The bench reaches this border with directed runs of exactly three and exactly four bad frames, and then with a random frame stream in which bad frames are common enough that runs of every length up to four happen repeatedly. Phase search is driven by a random number of junk bits placed before the alignment symbol, so the number of slips needed varies. Random idle gaps with random bit_in values are inserted between bits throughout.

// File: rtl/ecf_pkg.sv
package ecf_pkg;

  // Per-frame decision handed from the lock controller to the word stage.
  typedef enum logic [1:0] {
    V_SKIP    = 2'd0,   // no word this cycle
    V_CLEAN   = 2'd1,   // word from a frame that met the framing rule
    V_SUSPECT = 2'd2    // word delivered from a bad frame while still locked
  } verdict_e;

endpackage

// File: rtl/ecf_shifter.sv
module ecf_shifter #(
  parameter int unsigned FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_stb,
  input  logic               bit_in,
  input  logic               slip_req,
  output logic               chk,
  output logic [FRAME_W-1:0] window
);
  localparam int unsigned CW = $clog2(FRAME_W);

  logic [FRAME_W-2:0] hist;
  logic [CW-1:0]      cnt;
  logic               slip_q;

  // Oldest bit in the MSB, the bit arriving now in the LSB.
  assign window = {hist, bit_in};
  assign chk    = bit_stb && !slip_q && (cnt == CW'(FRAME_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hist   <= '0;
      cnt    <= '0;
      slip_q <= 1'b0;
    end else if (bit_stb) begin
      hist <= window[FRAME_W-2:0];
      if (slip_q) begin
        slip_q <= 1'b0;          // swallow one bit: phase moves one later
      end else if (chk) begin
        cnt    <= '0;
        slip_q <= slip_req;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4: a pending slip only exists right at a frame boundary
  a_r4_slip_at_boundary: assert property (@(posedge clk) disable iff (rst)
    slip_q |-> (cnt == '0));

  // R9: without a strobe the bit counter keeps its value
  a_r9_idle_holds_count: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> $stable(cnt));

endmodule

// File: rtl/ecf_lock_fsm.sv
module ecf_lock_fsm
  import ecf_pkg::*;
#(
  parameter int unsigned FRAME_W  = 12,
  parameter int unsigned ACQ_RUN  = 8,
  parameter int unsigned LOSS_RUN = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chk,
  input  logic [FRAME_W-1:0] window,
  output logic               lock_n,
  output logic               slip_req,
  output verdict_e           verdict
);
  localparam int unsigned GW = (ACQ_RUN  > 2) ? $clog2(ACQ_RUN)  : 1;
  localparam int unsigned BW = (LOSS_RUN > 2) ? $clog2(LOSS_RUN) : 1;

  logic          lock_n_q;
  logic [GW-1:0] good_cnt;
  logic [BW-1:0] bad_cnt;
  logic          frame_ok;
  logic          locked;
  logic          last_bad;
  logic          last_good;

  assign frame_ok  = window[FRAME_W-1] & ~window[0];
  assign locked    = ~lock_n_q;
  assign last_bad  = (bad_cnt  == BW'(LOSS_RUN - 1));
  assign last_good = (good_cnt == GW'(ACQ_RUN - 1));
  assign lock_n    = lock_n_q;

  always_comb begin
    slip_req = 1'b0;
    verdict  = V_SKIP;
    if (chk) begin
      if (!locked) begin
        slip_req = !frame_ok;
      end else if (frame_ok) begin
        verdict = V_CLEAN;
      end else if (last_bad) begin
        slip_req = 1'b1;
      end else begin
        verdict = V_SUSPECT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_n_q <= 1'b1;
      good_cnt <= '0;
      bad_cnt  <= '0;
    end else if (chk) begin
      if (!locked) begin
        if (!frame_ok) begin
          good_cnt <= '0;
        end else if (last_good) begin
          lock_n_q <= 1'b0;
          good_cnt <= '0;
          bad_cnt  <= '0;
        end else begin
          good_cnt <= good_cnt + 1'b1;
        end
      end else begin
        if (frame_ok) begin
          bad_cnt <= '0;
        end else if (last_bad) begin
          lock_n_q <= 1'b1;
          bad_cnt  <= '0;
          good_cnt <= '0;
        end else begin
          bad_cnt <= bad_cnt + 1'b1;
        end
      end
    end
  end

  // R3: lock is only gained on a good frame that completes the acquisition run
  a_r3_lock_needs_run: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_n_q) |-> ($past(chk) && $past(frame_ok) && $past(good_cnt) == GW'(ACQ_RUN - 1)));

  // R6: lock is only lost on the bad frame that completes the loss run
  a_r6_loss_needs_run: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_n_q) |-> ($past(chk) && !$past(frame_ok) && $past(bad_cnt) == BW'(LOSS_RUN - 1)));

endmodule

// File: rtl/ecf_word_out.sv
module ecf_word_out
  import ecf_pkg::*;
#(
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned FRAME_W = DATA_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  verdict_e           verdict,
  input  logic [FRAME_W-1:0] window,
  output logic               word_valid,
  output logic [DATA_W-1:0]  word_data,
  output logic               word_suspect
);
  logic [DATA_W-1:0] payload;

  // Payload bit 0 is the first bit after the framing bit (window MSB).
  for (genvar i = 0; i < DATA_W; i++) begin : g_order
    assign payload[i] = window[FRAME_W-2-i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_valid   <= 1'b0;
      word_suspect <= 1'b0;
      word_data    <= '0;
    end else begin
      word_valid   <= (verdict != V_SKIP);
      word_suspect <= (verdict == V_SUSPECT);
      word_data    <= (verdict != V_SKIP) ? payload : '0;
    end
  end

  // R7: a suspect flag never appears without a delivered word
  a_r7_suspect_has_word: assert property (@(posedge clk) disable iff (rst)
    word_suspect |-> word_valid);

  // R8: outputs are zero whenever no word is delivered
  a_r8_blank_data: assert property (@(posedge clk) disable iff (rst)
    !word_valid |-> (word_data == '0));

endmodule

// File: rtl/ecf_aligner.sv
module ecf_aligner
  import ecf_pkg::*;
#(
  parameter int unsigned DATA_W   = 10,
  parameter int unsigned ACQ_RUN  = 8,
  parameter int unsigned LOSS_RUN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              bit_in,
  output logic              lock_n,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data,
  output logic              word_suspect
);
  localparam int unsigned FRAME_W = DATA_W + 2;

  logic               chk;
  logic               slip_req;
  logic [FRAME_W-1:0] window;
  verdict_e           verdict;

  ecf_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .bit_stb  (bit_stb),
    .bit_in   (bit_in),
    .slip_req (slip_req),
    .chk      (chk),
    .window   (window)
  );

  ecf_lock_fsm #(
    .FRAME_W  (FRAME_W),
    .ACQ_RUN  (ACQ_RUN),
    .LOSS_RUN (LOSS_RUN)
  ) u_lock (
    .clk      (clk),
    .rst      (rst),
    .chk      (chk),
    .window   (window),
    .lock_n   (lock_n),
    .slip_req (slip_req),
    .verdict  (verdict)
  );

  ecf_word_out #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_word (
    .clk          (clk),
    .rst          (rst),
    .verdict      (verdict),
    .window       (window),
    .word_valid   (word_valid),
    .word_data    (word_data),
    .word_suspect (word_suspect)
  );

  // R8: no word is ever delivered while the lock output reads unlocked
  a_r8_no_word_unlocked: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> !lock_n);

  // R5: a word strobe lasts a single cycle (frames are at least 12 strobes apart)
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

endmodule

// File: tb/ecf_aligner_bench.sv
`timescale 1ns/1ps
module ecf_aligner_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       bit_stb;
  logic       bit_in;
  logic       lock_n;
  logic       word_valid;
  logic [9:0] word_data;
  logic       word_suspect;

  int  n_chk = 0;
  int  n_bad = 0;
  int  cyc   = 0;
  logic       s_valid, s_susp, s_lockn;
  logic [9:0] s_data;
  bit  gaps_on = 1'b0;
  bit  stray;

  always #2 clk = ~clk;   // 250 MHz

  ecf_aligner u_ecf_aligner (
    .clk (clk), .rst (rst), .bit_stb (bit_stb), .bit_in (bit_in),
    .lock_n (lock_n), .word_valid (word_valid), .word_data (word_data),
    .word_suspect (word_suspect)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bit_stb = 1'b0;
      bit_in  = 1'($urandom);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_stb = 1'b1;
    bit_in  = b;
    @(posedge clk);
    #1;
    s_valid = word_valid;
    s_susp  = word_suspect;
    s_lockn = lock_n;
    s_data  = word_data;
    if (gaps_on && $urandom_range(3) == 0) idle(int'($urandom_range(3, 1)));
  endtask

  // R2 frame order: framing bit, payload bit 0..9, closing bit
  task automatic send_frame(input logic [9:0] d, input logic st, input logic sp);
    stray = 1'b0;
    send_bit(st);
    if (s_valid) stray = 1'b1;
    for (int i = 0; i < 10; i++) begin
      send_bit(d[i]);
      if (s_valid) stray = 1'b1;
    end
    send_bit(sp);
    check(!stray, "R5 no word mid-frame", int'(stray), 0);
  endtask

  function automatic logic [1:0] bad_kind();
    // returns {framing, closing} for a frame that breaks the rule
    case ($urandom_range(2))
      0:       return 2'b00;
      1:       return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic expect_word(input string tag, input logic [9:0] d, input logic susp);
    check(s_valid === 1'b1 && s_lockn === 1'b0, {tag, " valid+lock"}, int'({s_valid, s_lockn}), 2);
    check(s_data === d, {tag, " data"}, int'(s_data), int'(d));
    check(s_susp === susp, {tag, " suspect"}, int'(s_susp), int'(susp));
  endtask

  task automatic reacquire();
    logic [9:0] d;
    send_bit(1'($urandom));   // consumed by the pending one-bit phase slip (R4)
    for (int k = 0; k < 8; k++) begin
      d = 10'($urandom);
      send_frame(d, 1'b1, 1'b0);
      if (k < 7)
        check(s_lockn === 1'b1 && s_valid === 1'b0, "R3 no lock before eighth",
              int'({s_lockn, s_valid}), 2);
      else
        check(s_lockn === 1'b0 && s_valid === 1'b0, "R3 lock on eighth, not delivered",
              int'({s_lockn, s_valid}), 0);
    end
  endtask

  initial begin
    int         strobes;
    int         offs;
    int         bad_run;
    int         pidx;
    bit         quiet;
    logic [9:0] d;
    logic [1:0] bk;

    void'($urandom(32'h5EED_0C1A));
    rst = 1'b1; bit_stb = 1'b0; bit_in = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check(lock_n === 1'b1, "R1 lock_n after reset", int'(lock_n), 1);
    check(word_valid === 1'b0 && word_suspect === 1'b0, "R1 strobes after reset",
          int'({word_valid, word_suspect}), 0);
    check(word_data === 10'd0, "R1 data after reset", int'(word_data), 0);

    // Phase search on the alignment symbol from a random offset (R4, R8)
    offs = int'($urandom_range(11));
    for (int i = 0; i < offs; i++) send_bit(1'($urandom));
    strobes = 0; pidx = 0; quiet = 1'b1;
    while (strobes < 400) begin
      send_bit(pidx < 6 ? 1'b1 : 1'b0);
      strobes++;
      if (s_lockn === 1'b1 && (s_valid !== 1'b0 || s_data !== 10'd0 || s_susp !== 1'b0))
        quiet = 1'b0;
      if (s_lockn === 1'b0) break;
      pidx = (pidx + 1) % 12;
    end
    check(strobes <= 252, "R4 lock within bound", strobes, 252);
    check(pidx == 11, "R4 lock on closing bit", pidx, 11);
    check(quiet, "R8 outputs blank while searching", int'(quiet), 1);
    check(s_valid === 1'b0, "R3 locking frame not delivered", int'(s_valid), 0);

    // Bit order (R2) and delivery (R5)
    send_frame(10'h001, 1'b1, 1'b0); expect_word("R2 bit0 first", 10'h001, 1'b0);
    send_frame(10'h200, 1'b1, 1'b0); expect_word("R2 bit9 last", 10'h200, 1'b0);
    send_frame(10'h2A5, 1'b1, 1'b0); expect_word("R5 word", 10'h2A5, 1'b0);

    // Idle cycles between bits are ignored (R9)
    d = 10'h1C3;
    begin
      logic [11:0] fr;
      fr = {1'b0, d[9:0], 1'b1};   // fr[11] sent last
      stray = 1'b0;
      for (int i = 0; i < 12; i++) begin
        idle(int'($urandom_range(5, 1)));
        send_bit(i == 0 ? 1'b1 : (i == 11 ? 1'b0 : d[i-1]));
      end
      expect_word("R9 idle gaps ignored", d, 1'b0);
    end

    // Three bad frames keep lock (R6, R7)
    for (int k = 0; k < 3; k++) begin
      d = 10'($urandom); bk = bad_kind();
      send_frame(d, bk[1], bk[0]);
      expect_word("R7 suspect word", d, 1'b1);
    end
    send_frame(10'h0F0, 1'b1, 1'b0);
    expect_word("R6 lock kept after three bad", 10'h0F0, 1'b0);

    // Four bad frames drop lock (R6, R7, R8)
    for (int k = 0; k < 4; k++) begin
      d = 10'($urandom); bk = bad_kind();
      send_frame(d, bk[1], bk[0]);
      if (k < 3) expect_word("R7 suspect before loss", d, 1'b1);
    end
    check(s_lockn === 1'b1, "R6 lock lost on fourth bad", int'(s_lockn), 1);
    check(s_valid === 1'b0 && s_data === 10'd0 && s_susp === 1'b0,
          "R7 R8 fourth bad not delivered", int'({s_valid, s_susp, s_data}), 0);
    reacquire();

    // Random frame stream with idle gaps
    gaps_on = 1'b1;
    bad_run = 0;
    for (int n = 0; n < 400; n++) begin
      d = 10'($urandom);
      if ($urandom_range(3) == 0) begin
        bk = bad_kind();
        send_frame(d, bk[1], bk[0]);
        if (bad_run == 3) begin
          check(s_lockn === 1'b1 && s_valid === 1'b0, "R6 random loss",
                int'({s_lockn, s_valid}), 2);
          reacquire();
          bad_run = 0;
        end else begin
          expect_word("R7 R9 random suspect", d, 1'b1);
          bad_run++;
        end
      end else begin
        send_frame(d, 1'b1, 1'b0);
        expect_word("R5 R9 random word", d, 1'b0);
        bad_run = 0;
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule